// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block handles the device side of OUT transactions for a single USB endpoint. Firmware sets up the endpoint first: where its receive buffer starts, how many bytes it may hold, whether the endpoint is enabled, stalled or allowed to interrupt, and the data toggle to expect. It then clears the not-ready flag to hand the buffer to the hardware. An upstream token decoder signals an OUT token for this endpoint and the PID of the data packet that follows. A receiver then delivers the payload as strobed bytes and closes it with an end-of-packet strobe that also carries the CRC or bit-stuff error status.

A good packet is written into the buffer and its length is recorded. The block then inverts the toggle, sets the not-ready flag so that firmware owns the buffer, answers with ACK and raises the endpoint interrupt. Firmware reads the byte count, then reads the bytes through a simple read port, and finally clears the interrupt and the not-ready flag. A stalled endpoint answers STALL, and a busy endpoint answers NAK. A corrupted or oversized packet gets no answer at all. A retransmitted packet with a stale toggle is acknowledged but not stored. A zero-length status packet is accepted with a count of zero.

Top module: `oep_rx_ctrl`

## Requirements
- R1: After reset the not-ready flag reads 1, the toggle reads 0, the byte count reads 0, the interrupt reads 0, no handshake is issued and the endpoint is disabled.
- R2: While the endpoint is disabled, OUT tokens and their packets produce no handshake and change no endpoint state.
- R3: When the stall flag is set at the time of the token, the handshake code is STALL (2), and toggle, count, not-ready flag and interrupt keep their values.
- R4: When the not-ready flag is set at the time of the token, the handshake code is NAK (1) and the endpoint state is unchanged. A firmware clear pulse sets the flag back to 0 so that the next packet can be accepted.
- R5: A packet closed with the error status gets no handshake, and toggle, count, not-ready flag and interrupt are unchanged.
- R6: A good packet whose PID toggle (DATA0=0, DATA1=1) equals the stored toggle is written byte by byte to consecutive addresses starting at the base address. It sets the count to its length, inverts the toggle and sets the not-ready flag. It is answered with ACK (0), one clock after the end-of-packet strobe, as a one-cycle pulse.
- R7: An accepted packet raises the interrupt only when the interrupt enable is set. The interrupt stays set until a firmware clear pulse.
- R8: A zero-length DATA1 packet that matches the toggle is accepted with ACK and sets the count to 0.
- R9: A packet whose PID toggle differs from the stored toggle is answered with ACK. It is not written to the buffer, and the toggle, count, not-ready flag and interrupt are unchanged.
- R10: A stored or toggle-mismatched packet longer than the configured size gets no handshake and changes no state. A packet exactly as long as the size is accepted.
- R11: When a packet completes in the same cycle as a firmware clear of the interrupt or of the not-ready flag, the completion wins and both flags read 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load configuration; also sets the not-ready flag |
| cfg_base | input | ADDR_W | Buffer base address |
| cfg_size | input | ADDR_W+1 | Buffer size in bytes |
| cfg_enable | input | 1 | Endpoint enable |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_toggle | input | 1 | Initial data toggle |
| cfg_stall | input | 1 | Stall flag |
| fw_nack_clr | input | 1 | Firmware pulse clearing the not-ready flag |
| fw_irq_clr | input | 1 | Firmware pulse clearing the interrupt |
| tok_out | input | 1 | OUT token for this endpoint |
| pid_vld | input | 1 | Data PID strobe |
| pid_data1 | input | 1 | Data PID is DATA1 |
| rx_valid | input | 1 | Payload byte strobe |
| rx_data | input | DATA_W | Payload byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_err | input | 1 | CRC or bit-stuff error, valid with rx_eop |
| rd_addr | input | ADDR_W | Firmware buffer read address |
| rd_data | output | DATA_W | Buffer read data, one cycle after rd_addr |
| hs_valid | output | 1 | Handshake pulse |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| irq | output | 1 | Endpoint interrupt |
| nack | output | 1 | Not-ready flag |
| toggle | output | 1 | Expected data toggle |
| byte_cnt | output | ADDR_W+1 | Length of the last accepted packet |

## Verification
Packet completion and firmware clear pulses can arrive in the same cycle, and both act on the interrupt and the not-ready flag. The bench asserts both clear pulses in the same cycle as the end-of-packet strobe of a good packet, and expects ACK with both flags still set afterwards. A separate clear pulse on a later cycle must then drop the interrupt.

// File: rtl/oep_pkg.sv
package oep_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PID,
    PH_DATA
  } phase_e;

  typedef enum logic [1:0] {
    DS_STORE,
    DS_DUP,
    DS_NAK,
    DS_STALL
  } disp_e;
endpackage

// File: rtl/oep_buf_ram.sv
module oep_buf_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/oep_ep_regs.sv
module oep_ep_regs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W:0]   cfg_size,
  input  logic              cfg_enable,
  input  logic              cfg_ie,
  input  logic              cfg_toggle,
  input  logic              cfg_stall,
  input  logic              fw_nack_clr,
  input  logic              fw_irq_clr,
  input  logic              commit,
  input  logic [ADDR_W:0]   commit_cnt,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W:0]   size,
  output logic              enable,
  output logic              stall,
  output logic              toggle,
  output logic              nack,
  output logic              irq,
  output logic [ADDR_W:0]   byte_cnt
);
  logic ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      size     <= '0;
      enable   <= 1'b0;
      ie       <= 1'b0;
      stall    <= 1'b0;
      toggle   <= 1'b0;
      nack     <= 1'b1;
      irq      <= 1'b0;
      byte_cnt <= '0;
    end else begin
      if (cfg_we) begin
        base   <= cfg_base;
        size   <= cfg_size;
        enable <= cfg_enable;
        ie     <= cfg_ie;
        stall  <= cfg_stall;
      end
      // completion has priority over firmware clears
      if (commit) begin
        toggle   <= ~toggle;
        nack     <= 1'b1;
        byte_cnt <= commit_cnt;
      end else begin
        if (cfg_we) toggle <= cfg_toggle;
        if (cfg_we) nack <= 1'b1;
        else if (fw_nack_clr) nack <= 1'b0;
      end
      if (commit && ie) irq <= 1'b1;
      else if (fw_irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/oep_pkt_fsm.sv
module oep_pkt_fsm
  import oep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_out,
  input  logic              pid_vld,
  input  logic              pid_data1,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_eop,
  input  logic              rx_err,
  input  logic              enable,
  input  logic              stall,
  input  logic              nack,
  input  logic              toggle,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   size,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic [ADDR_W:0]   commit_cnt,
  output logic              hs_valid,
  output logic [1:0]        hs_code
);
  phase_e          ph_q;
  disp_e           disp_q;
  logic            stall_s, nack_s, ovf_q;
  logic [ADDR_W:0] idx_q;
  logic            room, counted, good_end;

  assign room     = (idx_q < size);
  assign counted  = (disp_q == DS_STORE) || (disp_q == DS_DUP);
  assign good_end = (ph_q == PH_DATA) && rx_eop && !rx_err && !(counted && ovf_q);

  assign wr_en      = (ph_q == PH_DATA) && rx_valid && (disp_q == DS_STORE) && room;
  assign wr_addr    = base + idx_q[ADDR_W-1:0];
  assign wr_data    = rx_data;
  assign commit     = good_end && (disp_q == DS_STORE);
  assign commit_cnt = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      disp_q   <= DS_NAK;
      stall_s  <= 1'b0;
      nack_s   <= 1'b1;
      ovf_q    <= 1'b0;
      idx_q    <= '0;
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
    end else begin
      hs_valid <= 1'b0;
      if (tok_out && enable) begin
        ph_q    <= PH_PID;
        stall_s <= stall;
        nack_s  <= nack;
      end else begin
        case (ph_q)
          PH_PID: if (pid_vld) begin
            ph_q  <= PH_DATA;
            idx_q <= '0;
            ovf_q <= 1'b0;
            if (stall_s)                disp_q <= DS_STALL;
            else if (nack_s)            disp_q <= DS_NAK;
            else if (pid_data1 == toggle) disp_q <= DS_STORE;
            else                        disp_q <= DS_DUP;
          end
          PH_DATA: begin
            if (rx_valid) begin
              if (room) idx_q <= idx_q + 1'b1;
              else      ovf_q <= 1'b1;
            end
            if (rx_eop) begin
              ph_q     <= PH_IDLE;
              hs_valid <= good_end;
              case (disp_q)
                DS_STALL: hs_code <= HS_STALL;
                DS_NAK:   hs_code <= HS_NAK;
                default:  hs_code <= HS_ACK;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/oep_rx_ctrl.sv
module oep_rx_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W:0]   cfg_size,
  input  logic              cfg_enable,
  input  logic              cfg_ie,
  input  logic              cfg_toggle,
  input  logic              cfg_stall,
  input  logic              fw_nack_clr,
  input  logic              fw_irq_clr,
  input  logic              tok_out,
  input  logic              pid_vld,
  input  logic              pid_data1,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_eop,
  input  logic              rx_err,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              irq,
  output logic              nack,
  output logic              toggle,
  output logic [ADDR_W:0]   byte_cnt
);
  logic [ADDR_W-1:0] base, wr_addr;
  logic [ADDR_W:0]   size, commit_cnt;
  logic              enable, stall, commit, wr_en;
  logic [DATA_W-1:0] wr_data;

  oep_ep_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_enable(cfg_enable), .cfg_ie(cfg_ie), .cfg_toggle(cfg_toggle), .cfg_stall(cfg_stall),
    .fw_nack_clr(fw_nack_clr), .fw_irq_clr(fw_irq_clr), .commit(commit),
    .commit_cnt(commit_cnt), .base(base), .size(size), .enable(enable), .stall(stall),
    .toggle(toggle), .nack(nack), .irq(irq), .byte_cnt(byte_cnt)
  );

  oep_pkt_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .tok_out(tok_out), .pid_vld(pid_vld), .pid_data1(pid_data1),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .rx_err(rx_err),
    .enable(enable), .stall(stall), .nack(nack), .toggle(toggle), .base(base), .size(size),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
    .commit_cnt(commit_cnt), .hs_valid(hs_valid), .hs_code(hs_code)
  );

  oep_buf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/oep_rx_ctrl_chk.sv
module oep_rx_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic       fw_irq_clr,
  input logic       rx_eop,
  input logic       rx_err,
  input logic       hs_valid,
  input logic [1:0] hs_code,
  input logic       irq,
  input logic       nack,
  input logic       toggle
);
  a_r5_err_silent: assert property (@(posedge clk) disable iff (rst)
    (rx_eop && rx_err) |=> !hs_valid);

  a_r6_hs_pulse: assert property (@(posedge clk) disable iff (rst)
    hs_valid |=> !hs_valid);

  a_r6_toggle_acked: assert property (@(posedge clk) disable iff (rst)
    (!$stable(toggle) && !$past(cfg_we)) |-> (hs_valid && hs_code == 2'd0 && nack));

  a_r7_irq_from_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (hs_valid && hs_code == 2'd0));

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(irq) && !$past(fw_irq_clr)) |-> irq);
endmodule

bind oep_rx_ctrl oep_rx_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .fw_irq_clr(fw_irq_clr),
  .rx_eop(rx_eop), .rx_err(rx_err), .hs_valid(hs_valid), .hs_code(hs_code),
  .irq(irq), .nack(nack), .toggle(toggle)
);

// File: tb/oep_rx_ctrl_test.sv
module oep_rx_ctrl_test;
  localparam int AW = 6;
  localparam int DW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_enable = 0, cfg_ie = 0, cfg_toggle = 0, cfg_stall = 0;
  logic [AW-1:0] cfg_base = '0, rd_addr = '0;
  logic [AW:0] cfg_size = '0;
  logic fw_nack_clr = 0, fw_irq_clr = 0, tok_out = 0, pid_vld = 0, pid_data1 = 0;
  logic rx_valid = 0, rx_eop = 0, rx_err = 0;
  logic [DW-1:0] rx_data = '0;
  logic [DW-1:0] rd_data;
  logic hs_valid, irq, nack, toggle;
  logic [1:0] hs_code;
  logic [AW:0] byte_cnt;

  int checks = 0, fails = 0;
  bit done = 0;
  int q_code[$];
  string q_req[$];
  int m_cnt = 0;
  bit m_tog = 0, m_nack = 1, m_irq = 0;

  always #5 clk = ~clk;

  oep_rx_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_enable(cfg_enable), .cfg_ie(cfg_ie), .cfg_toggle(cfg_toggle), .cfg_stall(cfg_stall),
    .fw_nack_clr(fw_nack_clr), .fw_irq_clr(fw_irq_clr), .tok_out(tok_out), .pid_vld(pid_vld),
    .pid_data1(pid_data1), .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
    .rx_err(rx_err), .rd_addr(rd_addr), .rd_data(rd_data), .hs_valid(hs_valid),
    .hs_code(hs_code), .irq(irq), .nack(nack), .toggle(toggle), .byte_cnt(byte_cnt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected handshakes as the design issues them
  always @(negedge clk) begin
    if (!rst && hs_valid) begin
      if (q_code.size() == 0) begin
        checks++; fails++;
        $display("FAIL unexpected handshake: actual %0d expected none", hs_code);
      end else begin
        automatic int e = q_code.pop_front();
        automatic string r = q_req.pop_front();
        check(r, "handshake", hs_code, e);
      end
    end
  end

  task automatic state_chk(input string req);
    check(req, "nack", nack, m_nack);
    check(req, "toggle", toggle, m_tog);
    check(req, "irq", irq, m_irq);
    check(req, "byte_cnt", byte_cnt, m_cnt);
  endtask

  task automatic cfg(input int base, input int size, input bit en, input bit ie,
                     input bit tog, input bit stl);
    @(negedge clk);
    cfg_we = 1; cfg_base = AW'(base); cfg_size = (AW+1)'(size);
    cfg_enable = en; cfg_ie = ie; cfg_toggle = tog; cfg_stall = stl;
    @(negedge clk);
    cfg_we = 0;
    m_tog = tog; m_nack = 1;
  endtask

  task automatic fw(input bit irq_clr, input bit nack_clr);
    @(negedge clk);
    fw_irq_clr = irq_clr; fw_nack_clr = nack_clr;
    @(negedge clk);
    fw_irq_clr = 0; fw_nack_clr = 0;
    if (irq_clr) m_irq = 0;
    if (nack_clr) m_nack = 0;
  endtask

  // exp_hs < 0 means no handshake is expected
  task automatic send(input bit p1, input int n, input int v0, input bit err,
                      input bit clr_eop, input int exp_hs, input string req);
    @(negedge clk);
    tok_out = 1;
    @(negedge clk);
    tok_out = 0; pid_vld = 1; pid_data1 = p1;
    @(negedge clk);
    pid_vld = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = DW'(v0 + i);
      @(negedge clk);
    end
    rx_valid = 0;
    if (exp_hs >= 0) begin
      q_code.push_back(exp_hs);
      q_req.push_back(req);
    end
    rx_eop = 1; rx_err = err;
    fw_irq_clr = clr_eop; fw_nack_clr = clr_eop;
    @(negedge clk);
    rx_eop = 0; rx_err = 0; fw_irq_clr = 0; fw_nack_clr = 0;
    repeat (3) @(negedge clk);
    check(req, "handshake queue drained", q_code.size(), 0);
  endtask

  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    check(req, "buffer byte", rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", "hs_valid", hs_valid, 0);
    state_chk("R1");

    // R2 disabled endpoint ignores traffic
    send(0, 3, 8'h11, 0, 0, -1, "R2");
    state_chk("R2");

    // R6 good packet, R7 interrupt
    cfg(10, 8, 1, 1, 0, 0);
    fw(0, 1);
    send(0, 5, 8'h40, 0, 0, 0, "R6");
    m_cnt = 5; m_tog = 1; m_nack = 1; m_irq = 1;
    state_chk("R6");
    rd(10, 8'h40, "R6");
    rd(14, 8'h44, "R6");

    // R4 busy endpoint answers NAK
    send(1, 2, 8'h77, 0, 0, 1, "R4");
    state_chk("R4");

    // R9 toggle mismatch acknowledged, not stored
    fw(1, 1);
    send(0, 3, 8'h90, 0, 0, 0, "R9");
    state_chk("R9");
    rd(10, 8'h40, "R9");

    // R5 error packet silent
    send(1, 8, 8'h55, 1, 0, -1, "R5");
    state_chk("R5");

    // R10 oversize silent, exact size accepted
    send(1, 9, 8'h60, 0, 0, -1, "R10");
    state_chk("R10");
    send(1, 8, 8'h20, 0, 0, 0, "R10");
    m_cnt = 8; m_tog = 0; m_nack = 1; m_irq = 1;
    state_chk("R10");
    rd(10, 8'h20, "R10");
    rd(17, 8'h27, "R10");

    // R3 stall
    cfg(10, 8, 1, 1, 0, 1);
    fw(0, 1);
    send(0, 2, 8'h33, 0, 0, 2, "R3");
    state_chk("R3");

    // R7 clear pulse drops interrupt
    fw(1, 0);
    check("R7", "irq after clear", irq, 0);

    // R8 zero-length status packet; R7 no interrupt with enable off
    cfg(10, 8, 1, 0, 1, 0);
    fw(0, 1);
    send(1, 0, 0, 0, 0, 0, "R8");
    m_cnt = 0; m_tog = 0; m_nack = 1;
    state_chk("R8");
    check("R7", "irq with enable off", irq, 0);

    // R11 completion wins over same-cycle firmware clears
    cfg(10, 8, 1, 1, 0, 0);
    fw(0, 1);
    send(0, 2, 8'hA0, 0, 1, 0, "R11");
    m_cnt = 2; m_tog = 1; m_nack = 1; m_irq = 1;
    state_chk("R11");
    fw(1, 0);
    check("R11", "irq after later clear", irq, 0);

    finish_run();
  end
endmodule